// File: doc/BRIEF.md
# Two-Region Reconfiguration Sequencer

This block sequences a chain of hardware tasks across a device that is divided into two partially reconfigurable regions. Only one region runs a task at any time. While it runs, the sequencer asks an external configuration port to load the next task into the other, idle region. When the running task finishes, the task already loaded in the other region is started. The region the finished task freed then receives the task after that. The first task of a sequence is loaded with nothing else overlapped. Data passed between tasks lives in registers outside both regions, so a region can be overwritten as soon as its task has finished.

A task may be marked conditional. Its two possible successors are the next two task indices, and the flow rejoins at the index after them. In polling mode the successor is fetched only once the predicate is known. In prediction mode a per-task hint picks a successor to load ahead of time. If the predicate disagrees with the hint, the correct successor is reloaded before it may start. Three cycle counters report the time the sequence was busy, the time a load was in flight, and the time a load overlapped a running task.

The configuration request is a valid/ready stream. The sequencer raises `cfg_valid` with a region and a task index and holds all three unchanged until it samples `cfg_ready` high. That edge is the handshake. The port may stall `cfg_ready` for any number of cycles. After the handshake the sequencer raises no new request until the port pulses `cfg_done` for that load. All other pins are plain level or pulse signals.

Top module: `dual_region_seq`

## Requirements
- R1: A synchronous active-high `rst` clears every output: `seq_busy`, `seq_done`, `cfg_valid`, `task_start` and `region_valid` are low, the counters read zero, and both regions count as empty.
- R2: A one-cycle `go` pulse while `seq_busy` is low samples `task_count`, `cond_mask`, `hint_mask` and `predict_en`. It then requests task 0 into region 0. A `go` while `seq_busy` is high is ignored, and the running sequence is unchanged.
- R3: While `cfg_valid` is high and `cfg_ready` is low, `cfg_valid`, `cfg_region` and `cfg_task` stay stable. At most one load is outstanding: after a handshake, no new request appears until `cfg_done` is seen.
- R4: `task_start[r]` pulses only after the load into region r has been acknowledged by `cfg_done` and the previously started task has raised `task_finish`. At most one region runs a task at any time, and no load targets the region that is running.
- R5: In a chain without conditional tasks, task k goes to region k mod 2. Task k+1 is loaded while task k runs, so the counted overlap is nonzero. The busy count is below the sum of all load and run latencies.
- R6: If bit c of `cond_mask` is 1, task c is conditional. Its successor is task c+1 when `branch_pred` (sampled in the cycle `task_finish` is high) is 0, and task c+2 when it is 1. Both arms continue at task c+3. Conditional tasks are never adjacent.
- R7: With `predict_en` = 0, the successor of a conditional task is requested only after that task finishes. With no other overlap available, the overlap count stays zero.
- R8: With `predict_en` = 1, bit c of `hint_mask` selects the arm loaded while task c runs (0 picks c+1, 1 picks c+2). On a correct hint the wrong arm is never loaded. On a wrong hint, the correct arm is loaded into the same region before it starts, and the busy count exceeds that of the correctly hinted run.
- R9: The sequence ends when the successor index of the finished task is at least `task_count`. `seq_done` then rises, `seq_busy` falls, and no further start is issued.
- R10: `busy_cycles` counts cycles with `seq_busy` high. `load_cycles` counts cycles from a request until its `cfg_done`. `overlap_cycles` counts those load cycles in which a task runs, and never exceeds `load_cycles`.
- R11: `region_valid[r]` is high while region r holds an acknowledged task that is waiting or running. It is low once that task finishes, so both bits are low after a completed sequence.
- R12: With `task_count` = 1, exactly one load (task 0, region 0) and one start occur before `seq_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start-of-sequence pulse |
| task_count | input | IDX_W+1 | Number of task indices in the sequence |
| cond_mask | input | MAX_TASKS | Bit c marks task c as conditional |
| hint_mask | input | MAX_TASKS | Predicted predicate for each conditional task |
| predict_en | input | 1 | 1 = load the hinted arm early, 0 = wait for the predicate |
| cfg_valid | output | 1 | Load request valid |
| cfg_ready | input | 1 | Configuration port accepts the request |
| cfg_region | output | 1 | Target region of the request |
| cfg_task | output | IDX_W | Task index to load |
| cfg_done | input | 1 | Pulse: the accepted load has completed |
| task_start | output | 2 | Per-region start pulse |
| task_finish | input | 2 | Per-region finish pulse |
| region_valid | output | 2 | Region holds a loaded task waiting or running |
| branch_pred | input | 1 | Predicate of the finishing conditional task |
| seq_busy | output | 1 | A sequence is in progress |
| seq_done | output | 1 | The last task has finished |
| busy_cycles | output | CNT_W | Cycles spent busy |
| load_cycles | output | CNT_W | Cycles with a load in flight |
| overlap_cycles | output | CNT_W | Load cycles spent while a task runs |

## Verification
The checker assumes that the environment obeys the handshakes. `task_finish[r]` pulses only for a region whose task was started and has not yet finished. `cfg_done` pulses once per accepted request and never before it. The mask inputs keep conditional tasks apart as R6 demands. The bench's responders are driven entirely by what the sequencer itself requests or starts: each finish is the end of a countdown set when the start was observed, and each `cfg_done` ends a countdown begun at the handshake. The stimulus masks place conditional tasks only at isolated indices, so every case stays within these assumptions.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY   = 2'd0,
    SLOT_LOADING = 2'd1,
    SLOT_READY   = 2'd2,
    SLOT_RUN     = 2'd3
  } slot_e;
endpackage

// File: rtl/rcs_succ.sv
// Successor of a task index: conditional tasks branch to +1/+2,
// the lower arm of a branch skips the upper one.
module rcs_succ #(
  parameter int MAX_TASKS = 16,
  parameter int NXT_W     = 6
) (
  input  logic [NXT_W-1:0]     cur,
  input  logic [MAX_TASKS-1:0] cond_mask,
  input  logic [MAX_TASKS-1:0] hint_mask,
  input  logic                 use_hint,
  input  logic                 branch_in,
  output logic [NXT_W-1:0]     nxt,
  output logic                 is_cond
);
  localparam int IDX_W = $clog2(MAX_TASKS);

  logic [NXT_W-1:0] prv;
  logic             cur_in, prv_in, prv_cond, branch;

  assign prv    = cur - NXT_W'(1);
  assign cur_in = cur < NXT_W'(MAX_TASKS);
  assign prv_in = (cur != '0) && (prv < NXT_W'(MAX_TASKS));

  always_comb begin
    is_cond  = cur_in ? cond_mask[cur[IDX_W-1:0]] : 1'b0;
    prv_cond = prv_in ? cond_mask[prv[IDX_W-1:0]] : 1'b0;
    branch   = use_hint ? (cur_in ? hint_mask[cur[IDX_W-1:0]] : 1'b0) : branch_in;
    if (is_cond)       nxt = cur + NXT_W'(1) + NXT_W'(branch);
    else if (prv_cond) nxt = cur + NXT_W'(2);
    else               nxt = cur + NXT_W'(1);
  end
endmodule

// File: rtl/rcs_cfg_port.sv
// Valid/ready request holder with one load outstanding at a time.
module rcs_cfg_port #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [IDX_W-1:0] issue_task,
  input  logic             issue_region,
  input  logic             cfg_ready,
  input  logic             cfg_done,
  output logic             cfg_valid,
  output logic [IDX_W-1:0] cfg_task,
  output logic             cfg_region,
  output logic             busy,
  output logic             land
);
  logic waiting;

  assign busy = cfg_valid | waiting;
  assign land = waiting & cfg_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_valid  <= 1'b0;
      waiting    <= 1'b0;
      cfg_task   <= '0;
      cfg_region <= 1'b0;
    end else begin
      if (issue && !busy) begin
        cfg_valid  <= 1'b1;
        cfg_task   <= issue_task;
        cfg_region <= issue_region;
      end else if (cfg_valid && cfg_ready) begin
        cfg_valid <= 1'b0;
        waiting   <= 1'b1;
      end else if (land) begin
        waiting <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rcs_counters.sv
module rcs_counters #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             active,
  input  logic             loading,
  input  logic             running,
  output logic [CNT_W-1:0] busy_cycles,
  output logic [CNT_W-1:0] load_cycles,
  output logic [CNT_W-1:0] overlap_cycles
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      busy_cycles    <= '0;
      load_cycles    <= '0;
      overlap_cycles <= '0;
    end else if (active) begin
      busy_cycles <= busy_cycles + CNT_W'(1);
      if (loading)             load_cycles    <= load_cycles + CNT_W'(1);
      if (loading && running)  overlap_cycles <= overlap_cycles + CNT_W'(1);
    end
  end
endmodule

// File: rtl/dual_region_seq.sv
module dual_region_seq #(
  parameter int MAX_TASKS = 16,
  parameter int CNT_W     = 24,
  localparam int IDX_W    = $clog2(MAX_TASKS),
  localparam int NUM_W    = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic [NUM_W-1:0]     task_count,
  input  logic [MAX_TASKS-1:0] cond_mask,
  input  logic [MAX_TASKS-1:0] hint_mask,
  input  logic                 predict_en,
  output logic                 cfg_valid,
  input  logic                 cfg_ready,
  output logic                 cfg_region,
  output logic [IDX_W-1:0]     cfg_task,
  input  logic                 cfg_done,
  output logic [1:0]           task_start,
  input  logic [1:0]           task_finish,
  output logic [1:0]           region_valid,
  input  logic                 branch_pred,
  output logic                 seq_busy,
  output logic                 seq_done,
  output logic [CNT_W-1:0]     busy_cycles,
  output logic [CNT_W-1:0]     load_cycles,
  output logic [CNT_W-1:0]     overlap_cycles
);
  import rcs_pkg::*;
  localparam int NXT_W = IDX_W + 2;

  logic                 active, done_q, running, run_reg, ex_reg, ex_valid;
  logic [NXT_W-1:0]     ex_task, run_task;
  logic [NUM_W-1:0]     num_q;
  logic [MAX_TASKS-1:0] cmask_q, hmask_q;
  logic                 predict_q;
  slot_e                slot_st   [2];
  logic [NXT_W-1:0]     slot_task [2];

  logic [NXT_W-1:0] g_nxt, r_nxt, tgt_task;
  logic             g_cond, r_cond, tgt_ok, held, issue, start_now, fin;
  logic             cfg_busy, land, accept_go;

  // Guess for the successor of the running task (hint for branches).
  rcs_succ #(.MAX_TASKS(MAX_TASKS), .NXT_W(NXT_W)) u_guess (
    .cur(run_task), .cond_mask(cmask_q), .hint_mask(hmask_q),
    .use_hint(1'b1), .branch_in(1'b0), .nxt(g_nxt), .is_cond(g_cond));

  // Resolved successor, using the predicate present with finish.
  rcs_succ #(.MAX_TASKS(MAX_TASKS), .NXT_W(NXT_W)) u_resolve (
    .cur(run_task), .cond_mask(cmask_q), .hint_mask(hmask_q),
    .use_hint(1'b0), .branch_in(branch_pred), .nxt(r_nxt), .is_cond(r_cond));

  assign accept_go = go && !active;
  assign fin       = active && running && task_finish[run_reg];
  assign start_now = active && !running && ex_valid &&
                     slot_st[ex_reg] == SLOT_READY && slot_task[ex_reg] == ex_task;

  // Load target: successor of the running task, else the next task to run.
  always_comb begin
    if (running) begin
      tgt_task = g_nxt;
      tgt_ok   = active && (!g_cond || predict_q) && (g_nxt < NXT_W'(num_q));
    end else begin
      tgt_task = ex_task;
      tgt_ok   = active && ex_valid;
    end
    held  = slot_task[ex_reg] == tgt_task &&
            (slot_st[ex_reg] == SLOT_LOADING || slot_st[ex_reg] == SLOT_READY);
    issue = tgt_ok && !held && !cfg_busy;
  end

  rcs_cfg_port #(.IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst(rst), .issue(issue), .issue_task(tgt_task[IDX_W-1:0]),
    .issue_region(ex_reg), .cfg_ready(cfg_ready), .cfg_done(cfg_done),
    .cfg_valid(cfg_valid), .cfg_task(cfg_task), .cfg_region(cfg_region),
    .busy(cfg_busy), .land(land));

  rcs_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(accept_go), .active(active),
    .loading(cfg_busy), .running(running),
    .busy_cycles(busy_cycles), .load_cycles(load_cycles),
    .overlap_cycles(overlap_cycles));

  // Region slot bookkeeping.
  always_ff @(posedge clk) begin
    for (int r = 0; r < 2; r++) begin
      if (rst || accept_go) begin
        slot_st[r]   <= SLOT_EMPTY;
        slot_task[r] <= '0;
      end else if (issue && ex_reg == 1'(r)) begin
        slot_st[r]   <= SLOT_LOADING;
        slot_task[r] <= tgt_task;
      end else if (land && cfg_region == 1'(r)) begin
        slot_st[r] <= SLOT_READY;
      end else if (start_now && ex_reg == 1'(r)) begin
        slot_st[r] <= SLOT_RUN;
      end else if (fin && run_reg == 1'(r)) begin
        slot_st[r] <= SLOT_EMPTY;
      end
    end
  end

  // Execution control.
  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      done_q     <= 1'b0;
      running    <= 1'b0;
      run_reg    <= 1'b0;
      run_task   <= '0;
      ex_reg     <= 1'b0;
      ex_task    <= '0;
      ex_valid   <= 1'b0;
      num_q      <= '0;
      cmask_q    <= '0;
      hmask_q    <= '0;
      predict_q  <= 1'b0;
      task_start <= '0;
    end else begin
      task_start <= '0;
      if (accept_go) begin
        active    <= task_count != '0;
        done_q    <= task_count == '0;
        running   <= 1'b0;
        ex_reg    <= 1'b0;
        ex_task   <= '0;
        ex_valid  <= task_count != '0;
        num_q     <= task_count;
        cmask_q   <= cond_mask;
        hmask_q   <= hint_mask;
        predict_q <= predict_en;
      end else if (active) begin
        if (start_now) begin
          running            <= 1'b1;
          run_task           <= ex_task;
          run_reg            <= ex_reg;
          ex_reg             <= ~ex_reg;
          task_start[ex_reg] <= 1'b1;
        end
        if (fin) begin
          running  <= 1'b0;
          ex_task  <= r_nxt;
          ex_valid <= r_nxt < NXT_W'(num_q);
          if (!(r_nxt < NXT_W'(num_q))) begin
            active <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign seq_busy = active;
  assign seq_done = done_q;
  always_comb begin
    for (int r = 0; r < 2; r++)
      region_valid[r] = slot_st[r] == SLOT_READY || slot_st[r] == SLOT_RUN;
  end
endmodule

// File: rtl/dual_region_seq_chk.sv
module dual_region_seq_chk #(
  parameter int CNT_W = 24,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_valid,
  input logic             cfg_ready,
  input logic             cfg_region,
  input logic [IDX_W-1:0] cfg_task,
  input logic [1:0]       task_start,
  input logic [1:0]       task_finish,
  input logic [1:0]       region_valid,
  input logic             seq_busy,
  input logic             seq_done,
  input logic [CNT_W-1:0] load_cycles,
  input logic [CNT_W-1:0] overlap_cycles
);
  logic [1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= (run_q | task_start) & ~task_finish;
  end

  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_task) && $stable(cfg_region));

  a_r4_one_start: assert property (@(posedge clk) disable iff (rst)
    $onehot0(task_start));

  a_r4_start_after_load: assert property (@(posedge clk) disable iff (rst)
    task_start[0] |-> region_valid[0] && $past(region_valid[0]));

  a_r4_start_after_load_r1: assert property (@(posedge clk) disable iff (rst)
    task_start[1] |-> region_valid[1] && $past(region_valid[1]));

  a_r4_no_start_while_running: assert property (@(posedge clk) disable iff (rst)
    (|task_start) |-> run_q == 2'b00);

  a_r4_no_load_into_running: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> !run_q[cfg_region]);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> !seq_busy && task_start == 2'b00);

  a_r10_overlap_bound: assert property (@(posedge clk) disable iff (rst)
    overlap_cycles <= load_cycles);
endmodule

bind dual_region_seq dual_region_seq_chk #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
  .cfg_region(cfg_region), .cfg_task(cfg_task), .task_start(task_start),
  .task_finish(task_finish), .region_valid(region_valid), .seq_busy(seq_busy),
  .seq_done(seq_done), .load_cycles(load_cycles), .overlap_cycles(overlap_cycles));

// File: tb/dual_region_seq_tb.sv
`timescale 1ns/1ps
module dual_region_seq_tb;
  localparam int MAXT = 16;
  localparam int CW   = 24;
  localparam int IW   = $clog2(MAXT);

  logic            clk = 1'b0, rst = 1'b1, go = 1'b0;
  logic [IW:0]     task_count = '0;
  logic [MAXT-1:0] cond_mask = '0, hint_mask = '0;
  logic            predict_en = 1'b0;
  logic            cfg_valid, cfg_ready = 1'b0, cfg_region, cfg_done = 1'b0;
  logic [IW-1:0]   cfg_task;
  logic [1:0]      task_start, task_finish = '0, region_valid;
  logic            branch_pred = 1'b0, seq_busy, seq_done;
  logic [CW-1:0]   busy_cycles, load_cycles, overlap_cycles;

  always #2.5 clk = ~clk;

  dual_region_seq #(.MAX_TASKS(MAXT), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .go(go), .task_count(task_count), .cond_mask(cond_mask),
    .hint_mask(hint_mask), .predict_en(predict_en), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_region(cfg_region), .cfg_task(cfg_task),
    .cfg_done(cfg_done), .task_start(task_start), .task_finish(task_finish),
    .region_valid(region_valid), .branch_pred(branch_pred), .seq_busy(seq_busy),
    .seq_done(seq_done), .busy_cycles(busy_cycles), .load_cycles(load_cycles),
    .overlap_cycles(overlap_cycles));

  int n_chk = 0, n_bad = 0;
  int viol, n_ld, n_ex, ld_cnt, serial, ld_sum;
  logic [63:0] ld_seq, ex_seq;
  logic [15:0] ld_regs;
  logic [MAXT-1:0] pred_mask = '0;
  logic pend_reg;
  logic [1:0] reg_loaded, running_tb;
  int region_task [2], run_id [2], run_cnt [2];

  function automatic int ld_lat(int t); return 4 + (t % 3); endfunction
  function automatic int ex_lat(int t); return 6 + 2 * (t % 2); endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Configuration port and task datapath responders.
  initial begin
    ld_cnt = 0; reg_loaded = '0; running_tb = '0; run_cnt[0] = 0; run_cnt[1] = 0;
    forever begin
      @(negedge clk);
      cfg_done = 1'b0;
      if (ld_cnt != 0) begin
        ld_cnt--;
        if (ld_cnt == 0) begin cfg_done = 1'b1; reg_loaded[pend_reg] = 1'b1; end
      end
      if (cfg_ready) cfg_ready = 1'b0;
      else if (cfg_valid) begin
        cfg_ready = 1'b1;
        ld_seq = (ld_seq << 4) | 64'(cfg_task);
        ld_regs = (ld_regs << 1) | 16'(cfg_region);
        n_ld++;
        region_task[cfg_region] = int'(cfg_task);
        reg_loaded[cfg_region] = 1'b0;
        pend_reg = cfg_region;
        ld_cnt = ld_lat(int'(cfg_task));
        serial += ld_cnt;
        ld_sum += ld_cnt;
      end
      for (int r = 0; r < 2; r++) begin
        task_finish[r] = 1'b0;
        if (run_cnt[r] != 0) begin
          run_cnt[r]--;
          if (run_cnt[r] == 0) begin
            task_finish[r] = 1'b1;
            branch_pred = pred_mask[run_id[r]];
            running_tb[r] = 1'b0;
          end
        end
        if (task_start[r]) begin
          if (!reg_loaded[r] || running_tb[1-r]) viol++;
          run_id[r] = region_task[r];
          ex_seq = (ex_seq << 4) | 64'(region_task[r]);
          n_ex++;
          run_cnt[r] = ex_lat(region_task[r]);
          running_tb[r] = 1'b1;
          serial += run_cnt[r];
        end
      end
    end
  end

  task automatic run_seq(int cnt, logic [MAXT-1:0] cm, logic [MAXT-1:0] hm,
                         bit pe, logic [MAXT-1:0] pm, bit mid_go);
    int i;
    ld_seq = '0; ex_seq = '0; ld_regs = '0; n_ld = 0; n_ex = 0;
    viol = 0; serial = 0; ld_sum = 0;
    @(negedge clk);
    task_count = (IW+1)'(cnt); cond_mask = cm; hint_mask = hm;
    predict_en = pe; pred_mask = pm; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    task_count = '0; cond_mask = '0; hint_mask = '0; predict_en = 1'b0;
    i = 0;
    while (!seq_done && i < 3000) begin
      @(negedge clk);
      i++;
      if (mid_go) go = (i == 20);
    end
    go = 1'b0;
    check(seq_done, "R9", "sequence completes (watchdog)", seq_done, 1);
    repeat (15) @(negedge clk);
  endtask

  task automatic t_reset();
    check(!seq_busy && !seq_done, "R1", "busy/done after reset", {seq_busy, seq_done}, 0);
    check(!cfg_valid && task_start == 0, "R1", "no request/start", {cfg_valid, task_start}, 0);
    check(region_valid == 0, "R1", "regions empty", region_valid, 0);
    check(busy_cycles == 0 && load_cycles == 0 && overlap_cycles == 0, "R1",
          "counters zero", busy_cycles + load_cycles + overlap_cycles, 0);
  endtask

  task automatic t_linear();
    run_seq(5, '0, '0, 1'b0, '0, 1'b0);
    check(ld_seq == 64'h01234 && n_ld == 5, "R5", "load order", ld_seq, 64'h01234);
    check(ld_regs == 16'b01010, "R5", "load regions", ld_regs, 16'b01010);
    check(ex_seq == 64'h01234 && n_ex == 5, "R5", "run order", ex_seq, 64'h01234);
    check(viol == 0, "R4", "start gating/exclusive run", viol, 0);
    check(overlap_cycles != 0, "R5", "overlap nonzero", overlap_cycles, 1);
    check(int'(busy_cycles) < serial, "R5", "busy below serial", busy_cycles, serial);
    check(int'(load_cycles) >= ld_sum && overlap_cycles <= load_cycles, "R10",
          "load count bounds", load_cycles, ld_sum);
    check(region_valid == 0 && !seq_busy, "R11", "regions clear after end", region_valid, 0);
  endtask

  int busy_good;

  task automatic t_predict_hit();
    run_seq(6, 16'h0002, 16'h0002, 1'b1, 16'h0002, 1'b0);
    busy_good = int'(busy_cycles);
    check(ld_seq == 64'h01345, "R8", "hit: loads", ld_seq, 64'h01345);
    check(ex_seq == 64'h01345, "R6", "upper arm then join", ex_seq, 64'h01345);
    check(viol == 0, "R4", "hit gating", viol, 0);
  endtask

  task automatic t_predict_miss();
    run_seq(6, 16'h0002, 16'h0000, 1'b1, 16'h0002, 1'b0);
    check(ld_seq == 64'h012345, "R8", "miss: reload", ld_seq, 64'h012345);
    check(ld_regs == 16'b010010, "R8", "miss: same region", ld_regs, 16'b010010);
    check(ex_seq == 64'h01345, "R8", "miss: run order", ex_seq, 64'h01345);
    check(viol == 0, "R4", "wrong arm never started", viol, 0);
    check(int'(busy_cycles) > busy_good, "R8", "miss costs time", busy_cycles, busy_good);
  endtask

  task automatic t_poll();
    run_seq(6, 16'h0002, 16'h0002, 1'b0, 16'h0000, 1'b0);
    check(ld_seq == 64'h01245 && ex_seq == 64'h01245, "R6", "lower arm path", ex_seq, 64'h01245);
    run_seq(6, 16'h0002, 16'h0000, 1'b0, 16'h0002, 1'b0);
    check(ld_seq == 64'h01345, "R7", "poll loads only chosen arm", ld_seq, 64'h01345);
    check(int'(busy_cycles) > busy_good, "R7", "poll slower than hit", busy_cycles, busy_good);
  endtask

  task automatic t_go_ignored();
    run_seq(5, '0, '0, 1'b0, '0, 1'b1);
    check(ld_seq == 64'h01234 && n_ld == 5, "R2", "mid go: loads unchanged", ld_seq, 64'h01234);
    check(ex_seq == 64'h01234 && n_ex == 5, "R2", "mid go: runs unchanged", ex_seq, 64'h01234);
  endtask

  task automatic t_single();
    run_seq(1, '0, '0, 1'b0, '0, 1'b0);
    check(n_ld == 1 && ld_seq == 0 && ld_regs == 0, "R12", "one load", n_ld, 1);
    check(n_ex == 1 && ex_seq == 0, "R12", "one run", n_ex, 1);
  endtask

  task automatic t_arm_last();
    run_seq(3, 16'h0001, 16'h0000, 1'b0, 16'h0000, 1'b0);
    check(ld_seq == 64'h01 && ld_regs == 16'b01, "R9", "arm ends sequence", ld_seq, 64'h01);
    check(ex_seq == 64'h01 && n_ex == 2, "R9", "arm runs last", ex_seq, 64'h01);
    check(overlap_cycles == 0, "R7", "poll chain no overlap", overlap_cycles, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_linear();
    t_predict_hit();
    t_predict_miss();
    t_poll();
    t_go_ignored();
    t_single();
    t_arm_last();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule